// File: doc/BRIEF.md
# Dual-ASIC Token Sequencer for Configuration and Readout

This block is the bus master for two front-end readout chips that share one serial clock line, one serial data line and one read/write line. Each chip has its own token input and its own token output. When the host asks for a sequence, the block picks chip A or chip B and sets the read/write line. It then raises the token input of that chip only and runs a gated serial clock. A write sequence shifts a 193-bit configuration frame out of a host-loaded shadow register. A read sequence steps through 33 clock periods: one for each of the 32 analog channels and one for the token.

The chips latch the data and the token on the falling edge of the serial clock and shift them on the rising edge. For that reason the block changes its data and token outputs only in the system cycle just after a rising edge. During a read, a one-cycle strobe with a channel number follows each of the first 32 rising edges, so that a downstream converter can digitise the peak and time outputs of that channel.

After the last falling edge the block waits for the selected chip's token output. If the token arrives, the block reports completion. If it does not arrive within a bounded time, the block sets a sticky error.

Top module: `tpc_tok_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, busy, done, err, asic_sclk, tki_a, tki_b and conv_stb are all 0.
- R2: A write command (cmd_read=0) drives asic_rw low and sends exactly 193 bits, sampled at the falling edges of asic_sclk. Shadow word w (cfg_addr, 0 to 6) bit b holds flat bit 32w+b. Channel c owns flat bits [6c+5:6c], and flat bit 192 is the ramp-select bit (0 internal ramp, 1 external ramp). The frame order is channel 0 first, each channel's 6 bits from most-significant first, and the ramp-select bit last.
- R3: A read command (cmd_read=1) drives asic_rw high for the whole sequence, produces exactly 33 rising and 33 falling edges of asic_sclk, and holds asic_sdo at 0.
- R4: Only the token input of the chip chosen by cmd_sel (0 = A, 1 = B) is ever raised. It is high before the first rising edge, still high at the first falling edge, and low again by the second falling edge. tki_a and tki_b are never high together.
- R5: asic_sdo changes during a sequence only in the system cycle that follows a rising edge of asic_sclk, so that each bit is stable at the falling edge that latches it.
- R6: asic_sclk has a period of DIV system cycles (default 8) and is high for DIV/2 of them. It is low whenever no sequence is running.
- R7: During a read, conv_stb pulses for one cycle after each of the first 32 rising edges, with conv_chan counting 0 to 31 in order. It does not pulse after the 33rd edge, and it never pulses during a write.
- R8: When the selected chip's token output is seen, done pulses for exactly one cycle and busy falls in that same cycle.
- R9: If the selected token output is not seen within TMO_SCLK serial periods (TMO_SCLK*DIV system cycles) after the last falling edge, err is set, busy falls and done does not pulse. err stays set until reset, even across later successful sequences.
- R10: A command presented while busy is high is ignored. It does not change the rate, the length, the read/write level or the chosen token.
- R11: Shadow writes presented while busy is high are ignored. Both the frame in progress and later frames carry the contents from before the write.
- R12: The token output of the chip that was not selected does not count as completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start request, sampled while idle |
| cmd_read | input | 1 | 1 = readout sequence, 0 = configuration write |
| cmd_sel | input | 1 | 0 = chip A, 1 = chip B |
| cfg_we | input | 1 | Shadow register word write strobe |
| cfg_addr | input | 3 | Shadow word index (0 to 6) |
| cfg_wdata | input | 32 | Shadow word data |
| tko_a | input | 1 | Token output of chip A |
| tko_b | input | 1 | Token output of chip B |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky token timeout flag |
| asic_sclk | output | 1 | Gated serial clock to both chips |
| asic_sdo | output | 1 | Shared serial data to both chips |
| asic_rw | output | 1 | Shared read/write line, high = read |
| tki_a | output | 1 | Token input of chip A |
| tki_b | output | 1 | Token input of chip B |
| conv_stb | output | 1 | Per-channel conversion strobe |
| conv_chan | output | 5 | Channel number for conv_stb |

## Verification
The bench captures every bit at the falling edge and compares it with a frame built from the field map. A wrong bit order, a missing ramp-select bit or data that changes on the wrong edge would each show up as mismatched frame bits. It aims a new command and a shadow write at the middle of a frame: a design that let them through would switch chips, change the read/write level or corrupt the rest of the frame. The token output of the wrong chip is driven to show that such a design would report done instead of timing out, and a successful sequence follows the timeout to catch an err flag that clears itself. The token edge timing and the clock period are also checked, since a design could still produce the right bit count while violating the latch-edge rule.

// File: rtl/tkseq_pkg.sv
`timescale 1ns/1ps
package tkseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/tkseq_clkgen.sv
`timescale 1ns/1ps
// Gated serial clock: high for the first half of each period, low otherwise
module tkseq_clkgen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic rise,
  output logic fall
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else begin
      cnt  <= (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
      sclk <= (cnt < CW'(HALF));
      rise <= (cnt == '0);
      fall <= (cnt == CW'(HALF));
    end
  end

  // R6
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sclk);
  // R5
  edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rise && fall));
endmodule

// File: rtl/tkseq_shadow.sv
`timescale 1ns/1ps
// Configuration shadow: word-addressed writes into a flat frame image
module tkseq_shadow #(
  parameter int NCH   = 32,
  parameter int FW    = 6,
  parameter int WORDW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic                 lock,
  input  logic [$clog2(((NCH*FW+1)+WORDW-1)/WORDW)-1:0] addr,
  input  logic [WORDW-1:0]     wdata,
  output logic [NCH*FW:0]      flat
);
  localparam int FRAME = NCH * FW + 1;
  localparam int NWORD = (FRAME + WORDW - 1) / WORDW;
  localparam int AW    = $clog2(NWORD);

  for (genvar i = 0; i < FRAME; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        flat[i] <= 1'b0;
      else if (we && !lock && addr == AW'(i / WORDW))
        flat[i] <= wdata[i % WORDW];
    end
  end

  // R11
  locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lock && $past(lock)) |-> $stable(flat));
endmodule

// File: rtl/tkseq_ctrl.sv
`timescale 1ns/1ps
module tkseq_ctrl
  import tkseq_pkg::*;
#(
  parameter int NCH      = 32,
  parameter int FW       = 6,
  parameter int DIV      = 8,
  parameter int TMO_SCLK = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_valid,
  input  logic                   cmd_read,
  input  logic                   cmd_sel,
  input  logic [NCH*FW:0]        frame,
  input  logic                   tko_a,
  input  logic                   tko_b,
  input  logic                   rise,
  input  logic                   fall,
  output logic                   run,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic                   sdo,
  output logic                   rw,
  output logic                   tki_a,
  output logic                   tki_b,
  output logic                   conv_stb,
  output logic [$clog2(NCH)-1:0] conv_chan
);
  localparam int FRAME   = NCH * FW + 1;
  localparam int IW      = $clog2(FRAME);
  localparam int NRW     = $clog2(FRAME + 1);
  localparam int CHW     = $clog2(NCH);
  localparam int PW      = $clog2(NCH + 1);
  localparam int SW      = $clog2(FW);
  localparam int TMO_CYC = TMO_SCLK * DIV;
  localparam int TW      = $clog2(TMO_CYC + 1);

  seq_state_t     state;
  logic           sel_q, rd_q, seen_q;
  logic [NRW-1:0] nrise;
  logic [PW-1:0]  ch_q, ch_n;
  logic [SW-1:0]  sub_q, sub_n;
  logic [IW-1:0]  idx_n;
  logic           bit_n;
  logic [TW-1:0]  wcnt;
  logic [1:0]     tko_a_sy, tko_b_sy;
  logic           tko_now;
  logic [NRW-1:0] len;

  // two-stage capture of the asynchronous token outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      tko_a_sy <= '0;
      tko_b_sy <= '0;
    end else begin
      tko_a_sy <= {tko_a_sy[0], tko_a};
      tko_b_sy <= {tko_b_sy[0], tko_b};
    end
  end
  assign tko_now = sel_q ? tko_b_sy[1] : tko_a_sy[1];
  assign len     = rd_q ? NRW'(NCH + 1) : NRW'(FRAME);

  // next frame pointer and the bit it selects
  always_comb begin
    if (sub_q == SW'(FW - 1)) begin
      ch_n  = ch_q + 1'b1;
      sub_n = '0;
    end else begin
      ch_n  = ch_q;
      sub_n = sub_q + 1'b1;
    end
    idx_n = IW'(ch_n) * IW'(FW) + IW'(FW - 1) - IW'(sub_n);
    bit_n = (ch_n >= PW'(NCH)) ? frame[FRAME-1] : frame[idx_n];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      run       <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      sdo       <= 1'b0;
      rw        <= 1'b0;
      tki_a     <= 1'b0;
      tki_b     <= 1'b0;
      conv_stb  <= 1'b0;
      conv_chan <= '0;
      sel_q     <= 1'b0;
      rd_q      <= 1'b0;
      seen_q    <= 1'b0;
      nrise     <= '0;
      ch_q      <= '0;
      sub_q     <= '0;
      wcnt      <= '0;
    end else begin
      done     <= 1'b0;
      conv_stb <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            state  <= ST_RUN;
            run    <= 1'b1;
            busy   <= 1'b1;
            rw     <= cmd_read;
            rd_q   <= cmd_read;
            sel_q  <= cmd_sel;
            tki_a  <= !cmd_sel;
            tki_b  <= cmd_sel;
            sdo    <= cmd_read ? 1'b0 : frame[FW-1];
            nrise  <= '0;
            ch_q   <= '0;
            sub_q  <= '0;
            seen_q <= 1'b0;
          end
        end
        ST_RUN: begin
          if (tko_now) seen_q <= 1'b1;
          if (rise) begin
            nrise <= nrise + 1'b1;
            if (nrise != '0) begin
              tki_a <= 1'b0;
              tki_b <= 1'b0;
              if (!rd_q) begin
                ch_q  <= ch_n;
                sub_q <= sub_n;
                sdo   <= bit_n;
              end
            end
            if (rd_q && nrise < NRW'(NCH)) begin
              conv_stb  <= 1'b1;
              conv_chan <= nrise[CHW-1:0];
            end
          end
          if (fall && nrise == len) begin
            run   <= 1'b0;
            sdo   <= 1'b0;
            wcnt  <= '0;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (tko_now || seen_q) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            rw    <= 1'b0;
            state <= ST_IDLE;
          end else if (wcnt == TW'(TMO_CYC - 1)) begin
            err   <= 1'b1;
            busy  <= 1'b0;
            rw    <= 1'b0;
            state <= ST_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  one_token_chk: assert property (@(posedge clk) disable iff (rst)
    !(tki_a && tki_b));
  // R4
  token_in_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (tki_a || tki_b) |-> busy);
  // R5
  sdo_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && $past(state) == ST_RUN && sdo != $past(sdo)) |-> $past(rise));
  // R7
  stb_read_only_chk: assert property (@(posedge clk) disable iff (rst)
    conv_stb |-> rw);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(err) |-> err);
  // R10
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> ($stable(sel_q) && $stable(rd_q)));
endmodule

// File: rtl/tpc_tok_seq.sv
`timescale 1ns/1ps
module tpc_tok_seq #(
  parameter int NCH      = 32,
  parameter int FW       = 6,
  parameter int DIV      = 8,
  parameter int TMO_SCLK = 16,
  parameter int WORDW    = 32,
  localparam int FRAME   = NCH * FW + 1,
  localparam int AW      = $clog2((FRAME + WORDW - 1) / WORDW),
  localparam int CHW     = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_read,
  input  logic             cmd_sel,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [WORDW-1:0] cfg_wdata,
  input  logic             tko_a,
  input  logic             tko_b,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             asic_sclk,
  output logic             asic_sdo,
  output logic             asic_rw,
  output logic             tki_a,
  output logic             tki_b,
  output logic             conv_stb,
  output logic [CHW-1:0]   conv_chan
);
  logic [FRAME-1:0] frame;
  logic             run, rise, fall;

  tkseq_shadow #(.NCH(NCH), .FW(FW), .WORDW(WORDW)) u_shadow (
    .clk(clk), .rst(rst), .we(cfg_we), .lock(busy),
    .addr(cfg_addr), .wdata(cfg_wdata), .flat(frame)
  );

  tkseq_clkgen #(.DIV(DIV)) u_clkgen (
    .clk(clk), .rst(rst), .run(run),
    .sclk(asic_sclk), .rise(rise), .fall(fall)
  );

  tkseq_ctrl #(.NCH(NCH), .FW(FW), .DIV(DIV), .TMO_SCLK(TMO_SCLK)) u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_sel(cmd_sel),
    .frame(frame), .tko_a(tko_a), .tko_b(tko_b),
    .rise(rise), .fall(fall), .run(run),
    .busy(busy), .done(done), .err(err),
    .sdo(asic_sdo), .rw(asic_rw), .tki_a(tki_a), .tki_b(tki_b),
    .conv_stb(conv_stb), .conv_chan(conv_chan)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !(busy || done || err || asic_sclk || tki_a || tki_b || conv_stb));
endmodule

// File: tb/tpc_tok_seq_bench.sv
`timescale 1ns/1ps
module tpc_tok_seq_bench;
  localparam int DIV = 8;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_read = 1'b0, cmd_sel = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic tko_a = 1'b0, tko_b = 1'b0;
  logic busy, done, err, asic_sclk, asic_sdo, asic_rw, tki_a, tki_b, conv_stb;
  logic [4:0] conv_chan;

  always #2.5 clk = ~clk;

  tpc_tok_seq u_tpc_tok_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_sel(cmd_sel), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tko_a(tko_a), .tko_b(tko_b), .busy(busy),
    .done(done), .err(err), .asic_sclk(asic_sclk), .asic_sdo(asic_sdo),
    .asic_rw(asic_rw), .tki_a(tki_a), .tki_b(tki_b), .conv_stb(conv_stb),
    .conv_chan(conv_chan)
  );

  int total = 0, fails = 0;
  logic [192:0] exp_flat;
  bit cap [0:255];
  logic cur_sel, exp_rw, prev_sclk = 1'b0;
  int cyc = 0, rises, falls, r0, r1, f0, rw_bad, oth_ever, stb_cnt, stb_bad;
  int done_cnt, idle_bad;
  logic tki_r0, tki_f0, tki_f1;

  // stimulus table: {read, sel, tko mode (1 selected, 2 other chip), seed}
  localparam logic [11:0] VEC [0:5] = '{
    {1'b0, 1'b0, 2'd1, 8'd3},
    {1'b0, 1'b1, 2'd1, 8'd7},
    {1'b0, 1'b0, 2'd1, 8'd0},
    {1'b1, 1'b0, 2'd1, 8'd5},
    {1'b1, 1'b1, 2'd1, 8'd9},
    {1'b0, 1'b1, 2'd2, 8'd4}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int seed, input int w);
    if (seed == 0) return (w == 6) ? 32'h1 : 32'h0;
    return 32'(32'h9E3779B9 * 32'(seed * 7 + w + 1)) ^ {w[7:0], seed[7:0], 16'hA5C3};
  endfunction

  function automatic logic exp_bit(input int f);
    if (f >= 192) return exp_flat[192];
    return exp_flat[6 * (f / 6) + 5 - (f % 6)];
  endfunction

  // observer of the serial bus, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (asic_sclk && !prev_sclk) begin
      if (rises == 0) begin r0 = cyc; tki_r0 = cur_sel ? tki_b : tki_a; end
      if (rises == 1) r1 = cyc;
      rises++;
    end
    if (!asic_sclk && prev_sclk) begin
      if (falls == 0) begin f0 = cyc; tki_f0 = cur_sel ? tki_b : tki_a; end
      if (falls == 1) tki_f1 = tki_a | tki_b;
      if (falls < 256) cap[falls] = asic_sdo;
      if (asic_rw != exp_rw) rw_bad++;
      falls++;
    end
    if (cur_sel ? tki_a : tki_b) oth_ever++;
    if (conv_stb) begin
      if (conv_chan != 5'(stb_cnt)) stb_bad++;
      stb_cnt++;
    end
    if (done) done_cnt++;
    if (asic_sclk && !busy) idle_bad++;
    prev_sclk = asic_sclk;
  end

  task automatic load_pat(input int seed);
    for (int w = 0; w < 7; w++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'(w); cfg_wdata = pat(seed, w);
      for (int b = 0; b < 32; b++)
        if (32 * w + b < 193) exp_flat[32 * w + b] = cfg_wdata[b];
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_seq(input logic rd, input logic sel);
    @(posedge clk);
    #1;
    rises = 0; falls = 0; rw_bad = 0; oth_ever = 0; stb_cnt = 0; stb_bad = 0;
    done_cnt = 0; idle_bad = 0; tki_r0 = 0; tki_f0 = 0; tki_f1 = 1;
    cur_sel = sel; exp_rw = rd;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_read = rd; cmd_sel = sel;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_seq(input int len, input int mode);
    int lim;
    lim = 0;
    while (falls < len && lim < 4000) begin @(negedge clk); lim++; end
    repeat (2) @(negedge clk);
    if (mode == 1) begin if (cur_sel) tko_b = 1'b1; else tko_a = 1'b1; end
    if (mode == 2) begin if (cur_sel) tko_a = 1'b1; else tko_b = 1'b1; end
    repeat (3) @(negedge clk);
    tko_a = 1'b0; tko_b = 1'b0;
    lim = 0;
    while (busy && lim < 600) begin @(negedge clk); lim++; end
    repeat (2) @(negedge clk);
  endtask

  function automatic int frame_mism();
    int m = 0;
    for (int f = 0; f < 193; f++) if (cap[f] != exp_bit(f)) m++;
    return m;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset values while in reset
    chk("R1 busy", int'(busy), 0);
    chk("R1 flags", int'(done | err | conv_stb), 0);
    chk("R1 sclk/tki", int'(asic_sclk | tki_a | tki_b), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", int'(busy | err | asic_sclk), 0);

    for (int v = 0; v < 6; v++) begin
      logic rd, sel; int mode, len;
      rd = VEC[v][11]; sel = VEC[v][10]; mode = int'(VEC[v][9:8]);
      len = rd ? 33 : 193;
      load_pat(int'(VEC[v][7:0]));
      start_seq(rd, sel);
      finish_seq(len, mode);
      chk(rd ? "R3 rises" : "R2 rises", rises, len);
      chk(rd ? "R3 falls" : "R2 falls", falls, len);
      chk(rd ? "R3 rw high" : "R2 rw low", rw_bad, 0);
      chk("R4 token before first rise", int'(tki_r0), 1);
      chk("R4 token at first fall", int'(tki_f0), 1);
      chk("R4 token dropped", int'(tki_f1), 0);
      chk("R4 other token idle", oth_ever, 0);
      chk("R6 period", r1 - r0, DIV);
      chk("R6 high time", f0 - r0, DIV / 2);
      chk("R6 idle clock low", idle_bad, 0);
      if (rd) begin
        int nz = 0;
        for (int f = 0; f < 33; f++) if (cap[f]) nz++;
        chk("R3 sdo low", nz, 0);
        chk("R7 strobe count", stb_cnt, 32);
        chk("R7 strobe order", stb_bad, 0);
      end else begin
        chk("R2,R5 frame bits", frame_mism(), 0);
        chk("R2 ramp bit last", int'(cap[192]), int'(exp_flat[192]));
        chk("R7 no strobe on write", stb_cnt, 0);
      end
      if (mode == 2) begin
        chk("R12 other token no done", done_cnt, 0);
        chk("R9 err set", int'(err), 1);
      end else begin
        chk("R8 done pulse", done_cnt, 1);
        chk("R8 busy low", int'(busy), 0);
      end
    end

    // R9 err stays set across a good sequence
    start_seq(1'b1, 1'b0);
    finish_seq(33, 1);
    chk("R9 sticky err", int'(err), 1);
    chk("R8 done after err", done_cnt, 1);

    // R10 and R11: command and shadow write aimed at the middle of a frame
    load_pat(11);
    start_seq(1'b0, 1'b0);
    while (rises < 10) @(negedge clk);
    cmd_valid = 1'b1; cmd_read = 1'b1; cmd_sel = 1'b1;
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = ~pat(11, 0);
    @(negedge clk);
    cmd_valid = 1'b0; cfg_we = 1'b0;
    finish_seq(193, 1);
    chk("R10 length kept", rises, 193);
    chk("R10 rw kept", rw_bad, 0);
    chk("R10 no switch of token", oth_ever, 0);
    chk("R11 frame in progress", frame_mism(), 0);
    start_seq(1'b0, 1'b1);
    finish_seq(193, 1);
    chk("R11 later frame", frame_mism(), 0);

    // R1 reset clears the sticky error
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 err cleared", int'(err), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", int'(busy | tki_a | tki_b | asic_sclk), 0);

    summary();
    $finish;
  end
endmodule